// File: doc/BRIEF.md
# MDIO Management Register Controller

This block lets a host reach the management registers of an external Ethernet PHY through a single 32-bit word. One store places an opcode, a PHY address, a register address and, for writes, a 16-bit value into the word. The controller then generates a complete serial management frame on the MDC clock and MDIO data lines. The host polls one ready bit in the same word until the frame has ended. For a read, the 16 bits returned by the PHY replace the low half of the word.

The frame has a preamble of ones, the start pattern 01, the two opcode bits, the PHY address and the register address. A bus turnaround and a 16-bit data field follow. Every field goes out most significant bit first. MDC is derived from the system clock by a divider set by a parameter. MDIO only changes while MDC is low, and read data is sampled on the rising edge of MDC. The frame always runs for a fixed number of MDC periods, so the ready bit returns even when no PHY answers. The released line then reads as all ones.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset the word reads 0x1000_0000 (ready bit 28 set, every other bit 0), MDC is low and MDIO is not driven.
- R2: A host write starts a transaction. From the next cycle the word reads 0 in bit 28 and shows the written bits 27:0. Bits 31:29 always read 0, whatever was written to them.
- R3: Every frame drives PRE_LEN ones, then 01, then the opcode from bits 27:26, the PHY address from bits 25:21 and the register address from bits 20:16, each most significant bit first.
- R4: When the opcode is not 10, the controller drives the turnaround as 1 then 0, followed by bits 15:0 most significant bit first. MDIO stays driven for the whole frame.
- R5: When the opcode is 10 (read), MDIO is released from the first turnaround bit to the end of the frame. Sixteen bits sampled on the rising MDC edges of the data field land in bits 15:0, first bit as the most significant. Bits 27:16 keep the command.
- R6: A read with no PHY driving the line returns 0xFFFF in bits 15:0.
- R7: Bit 28 reads 1 exactly 2*MDC_HALF*(PRE_LEN+32) system cycles after the cycle in which the write was accepted.
- R8: While busy, MDC is high for exactly MDC_HALF system cycles per period, a frame has PRE_LEN+32 rising MDC edges, and MDIO output and enable change only while MDC is low.
- R9: A write during a transaction abandons it at once and starts the new one. Bit 28 returns only after the new frame's full length.
- R10: While bit 28 reads 1, MDC is low and MDIO is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe for the command word |
| wr_data | input | 32 | Command word being written |
| rd_data | output | 32 | Command word readback: ready bit 28, command 27:16, data 15:0 |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | Management data line as seen at the pad |
| mdio_o | output | 1 | Management data driven out |
| mdio_oe | output | 1 | Output enable for the management data pad |

## Verification
The bench builds the controller with MDC_HALF set to 2 and the default 32-bit preamble. Each frame then takes 256 system cycles, so the run covers many transactions, including an abort in mid-frame. A divide of 2 keeps every MDC phase more than one cycle long. The half-period counter, the low-phase-only rule for MDIO changes and the exact completion count can therefore all be seen at cycle resolution. A bench PHY model answers reads with chosen patterns, or stays silent to show the all-ones result. The model also flags any cycle in which the controller and the PHY drive MDIO together.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef struct packed {
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] data;
    } mdio_cmd_t;

    localparam logic [1:0] OP_READ   = 2'b10;
    localparam logic [1:0] START_PAT = 2'b01;
    localparam logic [1:0] TA_DRIVE  = 2'b10;
    localparam int         READY_BIT = 28;

    function automatic logic is_read(input mdio_cmd_t c);
        return c.op == OP_READ;
    endfunction

    function automatic logic [31:0] frame_body(input mdio_cmd_t c);
        return {START_PAT, c.op, c.phy, c.regad, TA_DRIVE, c.data};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = run && !restart && (cnt == LAST);
    assign rise = tick && !mdc;
    assign fall = tick && mdc;

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_ser.sv
module mdio_frame_ser
    import mdio_pkg::*;
#(
    parameter int PRE = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  mdio_cmd_t   cmd,
    input  logic        rise,
    input  logic        fall,
    input  logic        mdio_i,
    output logic        busy,
    output logic        done_pulse,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rx_val
);
    localparam int TOTAL = PRE + 32;
    localparam int IW    = $clog2(TOTAL + 1);
    localparam logic [IW-1:0] PRE_END  = IW'(PRE);
    localparam logic [IW-1:0] TA_IDX   = IW'(PRE + 14);
    localparam logic [IW-1:0] DATA_IDX = IW'(PRE + 16);
    localparam logic [IW-1:0] LAST_IDX = IW'(TOTAL - 1);

    logic [IW-1:0] idx;
    logic [IW-1:0] pos;
    logic [31:0]   body;
    logic          rd;

    assign rd   = is_read(cmd);
    assign body = frame_body(cmd);
    assign pos  = idx - PRE_END;

    always_comb begin
        mdio_o  = 1'b1;
        mdio_oe = 1'b0;
        if (busy) begin
            mdio_oe = !(rd && idx >= TA_IDX);
            if (idx >= PRE_END)
                mdio_o = body[5'd31 - pos[4:0]];
        end
    end

    assign done_pulse = busy && fall && (idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            idx    <= '0;
            rx_val <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            idx    <= '0;
            rx_val <= '0;
        end else if (busy) begin
            if (rise && rd && idx >= DATA_IDX)
                rx_val <= {rx_val[14:0], mdio_i};
            if (fall) begin
                if (idx == LAST_IDX)
                    busy <= 1'b0;
                else
                    idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
    import mdio_pkg::*;
#(
    parameter int MDC_HALF = 4,
    parameter int PRE_LEN  = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        mdc,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe
);
    mdio_cmd_t   cmd_q;
    logic        ready_q;
    logic        busy;
    logic        done_pulse;
    logic        rise;
    logic        fall;
    logic [15:0] rx_val;

    mdio_mdc_gen #(.HALF(MDC_HALF)) clkgen_i (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .restart (wr_en),
        .mdc     (mdc),
        .rise    (rise),
        .fall    (fall)
    );

    mdio_frame_ser #(.PRE(PRE_LEN)) ser_i (
        .clk        (clk),
        .rst        (rst),
        .start      (wr_en),
        .cmd        (cmd_q),
        .rise       (rise),
        .fall       (fall),
        .mdio_i     (mdio_i),
        .busy       (busy),
        .done_pulse (done_pulse),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .rx_val     (rx_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            ready_q <= 1'b1;
        end else if (wr_en) begin
            cmd_q   <= mdio_cmd_t'(wr_data[27:0]);
            ready_q <= 1'b0;
        end else if (done_pulse) begin
            ready_q <= 1'b1;
            if (is_read(cmd_q))
                cmd_q.data <= rx_val;
        end
    end

    assign rd_data = {3'b000, ready_q, cmd_q};
endmodule

// File: rtl/mdio_cmd_ctrl_chk.sv
module mdio_cmd_ctrl_chk #(
    parameter int DIV = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [31:0] rd_data,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    logic [15:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst)      hi_run <= '0;
        else if (mdc) hi_run <= hi_run + 1'b1;
        else          hi_run <= '0;
    end

    // R2: an accepted write clears the ready bit
    a_r2_ready_clears: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !rd_data[28]);

    // R2: the unused top bits never read 1
    a_r2_top_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[31:29] == 3'b000);

    // R8: MDIO output and enable hold across a high MDC phase
    a_r8_mdio_stable_high: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R8: a high MDC phase lasts exactly DIV cycles unless a write cut it
    a_r8_mdc_high_len: assert property (@(posedge clk) disable iff (rst)
        ($fell(mdc) && !$past(wr_en)) |-> (hi_run == 16'(DIV)));

    // R10: a ready controller leaves the bus quiet
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        rd_data[28] |-> (!mdc && !mdio_oe));
endmodule

bind mdio_cmd_ctrl mdio_cmd_ctrl_chk #(.DIV(MDC_HALF)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_data (rd_data),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/mdio_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module mdio_cmd_ctrl_tb_top;
    localparam int HALF  = 2;
    localparam int PRE   = 32;
    localparam int TOTAL = PRE + 32;
    localparam int EXP_CYC = 2 * HALF * TOTAL;
    localparam int NVEC  = 7;

    // {command word, phy answers, phy value}
    localparam logic [48:0] VEC [NVEC] = '{
        {32'h0472_ABCD, 1'b0, 16'h0000},
        {32'h0BE0_0000, 1'b1, 16'h5A3C},
        {32'h081F_1234, 1'b1, 16'h8001},
        {32'h08A5_0000, 1'b0, 16'h0000},
        {32'hE555_0000, 1'b0, 16'h0000},
        {32'h0021_0001, 1'b0, 16'h0000},
        {32'h0BFF_FFFF, 1'b1, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i;

    logic        phy_en = 1'b0;
    logic [15:0] phy_val = '0;
    logic        phy_drv = 1'b0;
    logic        phy_bit = 1'b1;
    logic        clash = 1'b0;
    logic [63:0] obits = '0;
    logic [63:0] oebits = '0;
    int          nrise = 0;
    int          checks = 0;
    int          fails = 0;
    bit          finished = 0;

    always #2.5 clk = ~clk;

    assign mdio_i = phy_drv ? phy_bit : 1'b1;

    mdio_cmd_ctrl #(.MDC_HALF(HALF), .PRE_LEN(PRE)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .mdc     (mdc),
        .mdio_i  (mdio_i),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

    always @(posedge mdc) begin
        obits  <= {obits[62:0], mdio_o};
        oebits <= {oebits[62:0], mdio_oe};
        nrise  <= nrise + 1;
    end

    // PHY model: sets up the next bit while MDC is low
    always @(negedge mdc) begin
        phy_drv <= 1'b0;
        phy_bit <= 1'b1;
        if (phy_en && nrise == PRE + 15) begin
            phy_drv <= 1'b1;
            phy_bit <= 1'b0;
        end else if (phy_en && nrise >= PRE + 16 && nrise <= PRE + 31) begin
            phy_drv <= 1'b1;
            phy_bit <= phy_val[15 - (nrise - PRE - 16)];
        end
    end

    always @(posedge clk) if (mdio_oe && phy_drv) clash <= 1'b1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] cmd, input logic en, input logic [15:0] val);
        @(negedge clk);
        phy_en  = en;
        phy_val = val;
        phy_drv = 1'b0;
        clash   = 1'b0;
        nrise   = 0;
        wr_data = cmd;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
        chk(rd_data == {4'b0000, cmd[27:0]}, "R2 readback after write",
            64'(rd_data), 64'({4'b0000, cmd[27:0]}));
    endtask

    task automatic finish_txn(input logic [31:0] cmd, input logic en,
                              input logic [15:0] val);
        int cyc = 0;
        logic rd = (cmd[27:26] == 2'b10);
        logic [63:0] exp_o = {32'hFFFF_FFFF, 2'b01, cmd[27:16], 2'b10, cmd[15:0]};
        logic [63:0] exp_oe = rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
        logic [31:0] exp_w = {4'b0001, cmd[27:16],
                              rd ? (en ? val : 16'hFFFF) : cmd[15:0]};
        while (!rd_data[28] && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc == EXP_CYC, "R7 completion cycles", 64'(cyc), 64'(EXP_CYC));
        chk(obits[63:18] == exp_o[63:18], "R3 preamble and header bits",
            obits, exp_o);
        chk(oebits == exp_oe, rd ? "R5 bus released for read" : "R4 bus driven for write",
            oebits, exp_oe);
        if (!rd)
            chk(obits[17:0] == exp_o[17:0], "R4 turnaround and data bits",
                64'(obits[17:0]), 64'(exp_o[17:0]));
        chk(rd_data == exp_w, (rd && !en) ? "R6 silent PHY reads ones" : "R5 final word",
            64'(rd_data), 64'(exp_w));
        chk(nrise == TOTAL, "R8 MDC edges per frame", 64'(nrise), 64'(TOTAL));
        chk(!mdc && !mdio_oe, "R10 idle bus after ready",
            64'({mdc, mdio_oe}), 64'(0));
        chk(!clash, "R5 no drive contention", 64'(clash), 64'(0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rd_data == 32'h1000_0000, "R1 reset word", 64'(rd_data), 64'h1000_0000);
        chk(!mdc && !mdio_oe, "R1 reset bus", 64'({mdc, mdio_oe}), 64'(0));

        for (int i = 0; i < NVEC; i++) begin
            issue(VEC[i][48:17], VEC[i][16], VEC[i][15:0]);
            finish_txn(VEC[i][48:17], VEC[i][16], VEC[i][15:0]);
        end

        // R9: abort a read in mid-frame with a write
        issue(32'h0BE0_0000, 1'b1, 16'h1111);
        repeat (37) @(negedge clk);
        chk(!rd_data[28], "R9 busy before abort", 64'(rd_data[28]), 64'(0));
        issue(32'h0466_C3A5, 1'b0, 16'h0000);
        finish_txn(32'h0466_C3A5, 1'b0, 16'h0000);

        // R9: abort landing while MDC is high
        issue(32'h0400_0000, 1'b0, 16'h0000);
        while (!mdc) @(negedge clk);
        issue(32'h0B21_0000, 1'b1, 16'hF00F);
        finish_txn(32'h0B21_0000, 1'b1, 16'hF00F);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule